// File: doc/BRIEF.md
# Phase Comparator With Selectable Window

This block measures how far the conditioned tach (FG) edge lags the internal phase reference strobe. It turns that lag into an 8-bit phase-control code for the speed servo while the loop is tracking. A free-running tick counter restarts on every reference strobe and is captured on a qualifying FG edge. The captured count is scaled linearly across a comparison window whose width is picked by a 2-bit range select. Wider windows also thin out the updates, so that only every second or fourth FG edge is used.

Outside tracking, the code follows the coarse frequency servo. It is driven to full scale while the motor is under speed and to zero when over speed or stopped. When a captured lag lands beyond the window, the code clamps at full scale. In the wide ranges this clamp is sticky: it stays in force until the lag has come back inside the window by a small margin. The result feeds an analog summing and filtering stage that lies outside this block.

Top module: `phase_window_cmp`

## Requirements
- R1: After reset, with tracking high and stop low, po_code is 128 until the first phase update.
- R2: While stop is high, po_code is 0 whatever the other inputs are.
- R3: With stop low and tracking low, po_code is 255 when underspeed is high and 0 when it is low.
- R4: The lag count c is the number of enabled ticks since the last enabled reference strobe. It is 0 in the cycle after the strobe and rises by one per tick_en cycle. With rng_sel 00 (standard) or 01 (test, treated as standard), every enabled FG edge updates po_code to floor(c*256/W), where W = 2^WIN_LOG2 ticks.
- R5: With rng_sel 10 (double), W is 3*2^WIN_LOG2 and only every second FG edge updates po_code. The edges in between leave it unchanged.
- R6: With rng_sel 11 (quadruple), W is 7*2^WIN_LOG2 and only every fourth FG edge updates po_code.
- R7: With fg_halved high, the number of FG edges per update doubles (2, 4 or 8).
- R8: An update with c >= W sets po_code to 255.
- R9: In the double and quadruple ranges, once an update has clamped, later updates give 255 until c < W - HYST. In the standard range there is no hold, and the next in-window update is scaled normally.
- R10: In a cycle with tick_en low, neither the lag counter nor the FG edge count advances, and fg_edge and ref_stb have no effect.
- R11: po_code holds between updates. Leaving tracking, or asserting stop, clears the edge count and hold state and returns the tracked code to 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Tick enable; all state advances only when high |
| ref_stb | input | 1 | Phase reference strobe, restarts the lag counter |
| fg_edge | input | 1 | Conditioned FG edge pulse |
| rng_sel | input | 2 | Window select: 00 standard, 01 test, 10 double, 11 quadruple |
| fg_halved | input | 1 | FG prescaler active; doubles edges per update |
| tracking | input | 1 | Frequency servo is inside the lock range |
| underspeed | input | 1 | Outside tracking: high for drive, low for brake |
| stop | input | 1 | Motor stop request |
| po_code | output | 8 | Phase-control code |

## Verification
The bench builds the block with CNT_W = 8, WIN_LOG2 = 4 and HYST = 2. With these values the windows are 16, 48 and 112 ticks, so each range, its exact scaling points (64, 128, 160, 240) and its clamp can be reached with lags of a few dozen cycles. A hysteresis margin of two ticks lets the bench place lags on both sides of the release point (47 held, 45 released in the double range). The same lag is also shown not to hold in the standard range.

// File: rtl/phase_window_pkg.sv
// Shared definitions for the phase comparator: range encoding and the
// per-range window multiplier and FG edge count per phase update.
package phase_window_pkg;

    typedef enum logic [1:0] {
        RNG_STD  = 2'b00,
        RNG_TEST = 2'b01,
        RNG_DBL  = 2'b10,
        RNG_QUAD = 2'b11
    } rng_e;

    // Window width as a multiple of the base window (2pi, 6pi, 14pi).
    function automatic logic [2:0] win_mult(input logic [1:0] r);
        case (rng_e'(r))
            RNG_DBL:  return 3'd3;
            RNG_QUAD: return 3'd7;
            default:  return 3'd1;
        endcase
    endfunction

    // Last edge index before an update (edges per update minus one).
    function automatic logic [2:0] edge_last(input logic [1:0] r, input logic halve);
        logic [3:0] n;
        case (rng_e'(r))
            RNG_DBL:  n = 4'd2;
            RNG_QUAD: n = 4'd4;
            default:  n = 4'd1;
        endcase
        if (halve) n = n << 1;
        return 3'(n - 4'd1);
    endfunction

    // True for the ranges whose limiter keeps a sticky clamp.
    function automatic logic is_wide(input logic [1:0] r);
        return r[1];
    endfunction

endpackage

// File: rtl/pw_lag_counter.sv
// Lag counter: counts enabled ticks since the last enabled reference
// strobe and saturates at its maximum. Assumes ref_stb is a one-cycle
// pulse; a strobe with tick_en low is ignored.
module pw_lag_counter #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             ref_stb,
    output logic [CNT_W-1:0] lag
);
    localparam logic [CNT_W-1:0] LAG_MAX = '1;

    // Restart on strobe, otherwise count up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n)                       lag <= '0;
        else if (tick_en && ref_stb)      lag <= '0;
        else if (tick_en && lag != LAG_MAX) lag <= lag + 1'b1;
    end

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && ref_stb) |=> (lag == '0)); // R4
    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(lag)); // R10
endmodule

// File: rtl/pw_edge_qual.sv
// FG edge qualifier: counts enabled FG edges while tracking and marks the
// edge that completes a group (1, 2 or 4 edges, doubled when the FG
// prescaler is active). Assumes fg_edge is a one-cycle pulse.
module pw_edge_qual
    import phase_window_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       fg_edge,
    input  logic       trk,
    input  logic [1:0] rng_sel,
    input  logic       fg_halved,
    output logic       upd
);
    logic [2:0] ecnt;
    logic [2:0] last;
    logic       edge_ok;

    // Decode the group length and flag the completing edge.
    always_comb begin
        last    = edge_last(rng_sel, fg_halved);
        edge_ok = tick_en && fg_edge && trk;
        upd     = edge_ok && (ecnt >= last);
    end

    // Advance the edge count; restart after a completing edge or off-track.
    always_ff @(posedge clk) begin
        if (!rst_n || !trk) ecnt <= '0;
        else if (upd)       ecnt <= '0;
        else if (edge_ok)   ecnt <= ecnt + 1'b1;
    end

    AST_QUAL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (ecnt == '0)); // R5
    AST_EDGE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (trk && !(tick_en && fg_edge)) |=> $stable(ecnt)); // R10
endmodule

// File: rtl/pw_scaler.sv
// Phase scaler and limiter: on each update maps the captured lag linearly
// onto 0..255 across the selected window, clamps at 255 beyond it, and in
// the wide ranges holds the clamp until the lag is HYST ticks inside.
// Assumes the widest window fits in the lag counter.
module pw_scaler
    import phase_window_pkg::*;
#(
    parameter int CNT_W    = 13,
    parameter int WIN_LOG2 = 10,
    parameter int HYST     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trk,
    input  logic             upd,
    input  logic [1:0]       rng_sel,
    input  logic [CNT_W-1:0] lag,
    output logic [7:0]       code
);
    localparam int QW = CNT_W + 8;
    localparam logic [QW-1:0] BASE   = QW'(1) << WIN_LOG2;
    localparam logic [QW-1:0] HYST_V = QW'(HYST);
    localparam logic [7:0]    MID    = 8'd128;

    logic [QW-1:0] win;
    logic [QW-1:0] quot;
    logic          over;
    logic          inside_rel;
    logic          wide;
    logic          held;

    // Window size, scaled quotient and limit comparisons.
    always_comb begin
        win        = BASE * QW'(win_mult(rng_sel));
        quot       = {lag, 8'h00} / win;
        over       = |quot[QW-1:8];
        inside_rel = (QW'(lag) + HYST_V) < win;
        wide       = is_wide(rng_sel);
    end

    // Update the code and the sticky-clamp flag on each qualified edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !trk) begin
            code <= MID;
            held <= 1'b0;
        end else if (upd) begin
            if (held && wide && !inside_rel) begin
                code <= 8'hFF;
            end else if (over) begin
                code <= 8'hFF;
                held <= wide;
            end else begin
                code <= quot[7:0];
                held <= 1'b0;
            end
        end
    end

    AST_LIMIT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (trk && upd && over) |=> (code == 8'hFF)); // R8
    AST_HOLD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (trk && !upd) |=> $stable(code)); // R11
    AST_STD_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !wide) |=> !held); // R9
    AST_OFFTRACK_MID: assert property (@(posedge clk) disable iff (!rst_n)
        !trk |=> (code == MID)); // R11
endmodule

// File: rtl/phase_window_cmp.sv
// Phase comparator top: ties the lag counter, FG edge qualifier and
// scaler together and selects the output code: zero on stop, full scale
// or zero from the frequency servo outside tracking, scaled phase inside.
module phase_window_cmp #(
    parameter int CNT_W    = 13,
    parameter int WIN_LOG2 = 10,
    parameter int HYST     = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       ref_stb,
    input  logic       fg_edge,
    input  logic [1:0] rng_sel,
    input  logic       fg_halved,
    input  logic       tracking,
    input  logic       underspeed,
    input  logic       stop,
    output logic [7:0] po_code
);
    logic             trk;
    logic             upd;
    logic [CNT_W-1:0] lag;
    logic [7:0]       trk_code;

    assign trk = tracking && !stop;

    pw_lag_counter #(.CNT_W(CNT_W)) u_lag (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .ref_stb(ref_stb), .lag(lag)
    );

    pw_edge_qual u_qual (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .fg_edge(fg_edge),
        .trk(trk), .rng_sel(rng_sel), .fg_halved(fg_halved), .upd(upd)
    );

    pw_scaler #(.CNT_W(CNT_W), .WIN_LOG2(WIN_LOG2), .HYST(HYST)) u_scale (
        .clk(clk), .rst_n(rst_n), .trk(trk), .upd(upd),
        .rng_sel(rng_sel), .lag(lag), .code(trk_code)
    );

    // Output select by servo state.
    always_comb begin
        if (stop)           po_code = 8'h00;
        else if (!tracking) po_code = underspeed ? 8'hFF : 8'h00;
        else                po_code = trk_code;
    end
endmodule

// File: tb/test_phase_window_cmp.sv
module test_phase_window_cmp;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic       ref_stb = 1'b0;
    logic       fg_edge = 1'b0;
    logic [1:0] rng_sel = 2'b00;
    logic       fg_halved = 1'b0;
    logic       tracking = 1'b0;
    logic       underspeed = 1'b0;
    logic       stop = 1'b0;
    logic [7:0] po_code;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    phase_window_cmp #(.CNT_W(8), .WIN_LOG2(4), .HYST(2)) i_phase_window_cmp (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ref_stb(ref_stb),
        .fg_edge(fg_edge), .rng_sel(rng_sel), .fg_halved(fg_halved),
        .tracking(tracking), .underspeed(underspeed), .stop(stop),
        .po_code(po_code)
    );

    function automatic int expect_code(int n, int w);
        if (n >= w) return 255;
        return (n * 256) / w;
    endfunction

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic check(string req, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Strobe, n idle ticks, then one FG edge; returns at the next negedge.
    task automatic fg_after(int n);
        ref_stb = 1'b1; cyc(); ref_stb = 1'b0;
        repeat (n) cyc();
        fg_edge = 1'b1; cyc(); fg_edge = 1'b0;
    endtask

    task automatic restart(logic [1:0] r, logic h);
        tracking = 1'b0; rng_sel = r; fg_halved = h; cyc();
        tracking = 1'b1; cyc();
    endtask

    task automatic t_reset();
        check("R3 reset brake", po_code, 0);
        tracking = 1'b1; cyc();
        check("R1 reset mid code", po_code, 128);
    endtask

    task automatic t_outside();
        tracking = 1'b0; underspeed = 1'b1; cyc();
        check("R3 drive full", po_code, 255);
        stop = 1'b1; cyc();
        check("R2 stop drive", po_code, 0);
        tracking = 1'b1; cyc();
        check("R2 stop tracking", po_code, 0);
        stop = 1'b0; underspeed = 1'b0; cyc();
        check("R11 after stop mid", po_code, 128);
    endtask

    task automatic t_std();
        restart(2'b00, 1'b0);
        fg_after(4);  check("R4 std n4", po_code, expect_code(4, 16));
        fg_after(15); check("R4 std n15", po_code, expect_code(15, 16));
        fg_after(16); check("R8 std at window", po_code, 255);
        fg_after(10); check("R9 std no hold", po_code, expect_code(10, 16));
        rng_sel = 2'b01;
        fg_after(8);  check("R4 test range as std", po_code, 128);
    endtask

    task automatic t_dbl();
        restart(2'b10, 1'b0);
        fg_after(30); check("R5 dbl odd edge ignored", po_code, 128);
        fg_after(12); check("R5 dbl n12", po_code, expect_code(12, 48));
        fg_after(5);  fg_after(50); check("R8 dbl clamp", po_code, 255);
        fg_after(5);  fg_after(47); check("R9 dbl held", po_code, 255);
        fg_after(5);  fg_after(45); check("R9 dbl released", po_code, expect_code(45, 48));
    endtask

    task automatic t_quad();
        restart(2'b11, 1'b0);
        fg_after(3); fg_after(3); fg_after(3);
        check("R6 quad three edges ignored", po_code, 128);
        fg_after(28); check("R6 quad n28", po_code, expect_code(28, 112));
    endtask

    task automatic t_halve();
        restart(2'b00, 1'b1);
        fg_after(4); check("R7 halved first edge ignored", po_code, 128);
        fg_after(4); check("R7 halved second edge", po_code, 64);
    endtask

    task automatic t_enable();
        restart(2'b00, 1'b0);
        ref_stb = 1'b1; cyc(); ref_stb = 1'b0;
        for (int i = 0; i < 6; i++) begin
            tick_en = (i % 2 == 1); cyc();
        end
        tick_en = 1'b1; fg_edge = 1'b1; cyc(); fg_edge = 1'b0;
        check("R10 counts only enabled ticks", po_code, expect_code(3, 16));
        tick_en = 1'b0; fg_edge = 1'b1; ref_stb = 1'b1; cyc(); cyc();
        fg_edge = 1'b0; ref_stb = 1'b0; tick_en = 1'b1;
        check("R10 disabled edge ignored", po_code, 48);
        repeat (5) cyc();
        check("R11 holds between updates", po_code, 48);
        tracking = 1'b0; cyc(); tracking = 1'b1; cyc();
        check("R11 off-track returns mid", po_code, 128);
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1; cyc();
        t_reset();
        t_outside();
        t_std();
        t_dbl();
        t_quad();
        t_halve();
        t_enable();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule